// File: doc/BRIEF.md
# Sampled-Clock Flip-Flop Emulator

This block stands in for an edge-triggered storage element in a design where every register runs on one fast global clock. The clock of the modelled element is treated as an ordinary data input. So are its data, its asynchronous reset and its per-bit set and clear. The block samples these inputs once per global cycle.

Each global cycle the block records the modelled clock, the modelled D and its own output Q. An active edge is a cycle in which the modelled clock sits at its active level while the recorded value did not. In that cycle Q takes the D recorded one global cycle earlier. In every other cycle Q repeats its recorded value.

A parameter selects the variant: a plain flop, a flop with asynchronous reset, or a flop with per-bit set and clear. Further parameters give the width, the clock polarity, the reset polarity, the reset value, and the set and clear polarities. Q is combinational from the history registers and the current inputs, so a reset, set or clear acts in the same global cycle in which it appears.

Top module: `sclk_ff_emu`

## Requirements
- R1: While `rst_n` is low, every history register holds its reset state: the recorded D and Q are zero. With no set input active, `q` reads zero.
- R2: In a global cycle with an active edge and no forcing input, `q` equals the value `md` had in the previous global cycle, not its current value.
- R3: In a global cycle without an active edge and with no forcing input, `q` equals the `q` of the previous global cycle.
- R4: With CLK_POL = 0, the active level is 0, so the flop loads on a 1-to-0 change of `mclk`. With CLK_POL = 1 it loads on a 0-to-1 change.
- R5: The recorded clock leaves reset at the active level. When `mclk` is held at the active level across reset release, the first cycles after release produce no edge and `q` stays zero.
- R6: In the reset variant, the reset stays in effect for the global cycle in which `mrst` is asserted and for the one cycle after it is deasserted.
- R7: With RST_POL = 0, `mrst` is active low. The reset is in effect when `mrst` is 0 in the current cycle or was 0 in the previous cycle.
- R8: While the reset is in effect, `q` equals RST_VALUE bit for bit. Once the reset ends, `q` keeps that value until the next active edge.
- R9: In the set/clear variant, an active bit of `mset` drives the same bit of `q` to 1 in the same cycle. The bit stays 1 after `mset` is released, until an edge or a clear changes it.
- R10: An active bit of `mclr` drives the same bit of `q` to 0 in the same cycle. When set and clear are both active on a bit, the clear wins.
- R11: SET_POL and CLR_POL give the active level of `mset` and `mclr` independently. A bit with polarity 0 is active when it is 0.
- R12: A reset that is in effect overrides an active edge in the same cycle, and `q` equals RST_VALUE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the history registers, released synchronously upstream |
| mclk | input | 1 | Modelled clock, sampled as data |
| md | input | WIDTH | Modelled data input |
| mrst | input | 1 | Modelled asynchronous reset, polarity set by RST_POL (reset variant only) |
| mset | input | WIDTH | Per-bit modelled set, polarity set by SET_POL (set/clear variant only) |
| mclr | input | WIDTH | Per-bit modelled clear, polarity set by CLR_POL (set/clear variant only) |
| q | output | WIDTH | Emulated flop output |

## Verification
Two functions can act in the same global cycle: an active modelled-clock edge and a reset that is in effect. In one case the reset input is asserted in the very cycle the clock becomes active. In the other, the edge falls in the cycle after the reset was removed, where only the recorded reset keeps it alive. In both cases `q` must show the reset value instead of the recorded D, and the next edge with no reset must load normally. Set and clear acting on the same bit are provoked the same way: the clear must win on that bit, while the other bits take the set or keep their value.

// File: rtl/sff_pkg.sv
package sff_pkg;

  // Variant of the emulated storage element
  typedef enum logic [1:0] {
    FFM_PLAIN  = 2'd0,
    FFM_ARST   = 2'd1,
    FFM_SETCLR = 2'd2
  } ffm_e;

  // Map a raw level to "active" under a polarity (1 = active high)
  function automatic logic lvl_on(input logic v, input bit pol);
    return pol ? v : ~v;
  endfunction

endpackage

// File: rtl/sff_clk_edge.sv
module sff_clk_edge
  import sff_pkg::*;
#(
  parameter bit CLK_POL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk,
  output logic act_edge
);

  logic pclk_q;
  logic pclk_n;

  // next state: record the modelled clock every global cycle
  always_comb begin
    pclk_n = mclk;
  end

  // power-up value equals the active level, so no spurious edge at wake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pclk_q <= CLK_POL;
    else        pclk_q <= pclk_n;
  end

  assign act_edge = lvl_on(mclk, CLK_POL) & ~lvl_on(pclk_q, CLK_POL);

  // R5
  no_edge_at_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !act_edge);

endmodule

// File: rtl/sff_hist.sv
module sff_hist #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_now,
  input  logic [WIDTH-1:0] q_now,
  output logic [WIDTH-1:0] d_past,
  output logic [WIDTH-1:0] q_past
);

  logic [WIDTH-1:0] d_nxt;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    d_nxt = d_now;
    q_nxt = q_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_past <= '0;
      q_past <= '0;
    end else begin
      d_past <= d_nxt;
      q_past <= q_nxt;
    end
  end

endmodule

// File: rtl/sff_rst_hold.sv
module sff_rst_hold
  import sff_pkg::*;
#(
  parameter bit RST_POL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mrst,
  output logic rst_on
);

  logic prst_q;
  logic prst_n;

  always_comb begin
    prst_n = mrst;
  end

  // recorded reset starts at the inactive level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prst_q <= ~RST_POL;
    else        prst_q <= prst_n;
  end

  // asserted if the reset is active now or was active one sample ago
  generate
    if (RST_POL) begin : g_hi
      assign rst_on = mrst | prst_q;
    end else begin : g_lo
      assign rst_on = ~(mrst & prst_q);
    end
  endgenerate

  // R6
  rst_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && lvl_on($past(mrst), RST_POL)) |-> rst_on);

endmodule

// File: rtl/sff_force.sv
module sff_force #(
  parameter int WIDTH   = 8,
  parameter bit SET_POL = 1'b1,
  parameter bit CLR_POL = 1'b1
) (
  input  logic [WIDTH-1:0] mset,
  input  logic [WIDTH-1:0] mclr,
  output logic [WIDTH-1:0] set_act,
  output logic [WIDTH-1:0] clr_act
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (SET_POL) begin : g_s_hi
      assign set_act[i] = mset[i];
    end else begin : g_s_lo
      assign set_act[i] = ~mset[i];
    end
    if (CLR_POL) begin : g_c_hi
      assign clr_act[i] = mclr[i];
    end else begin : g_c_lo
      assign clr_act[i] = ~mclr[i];
    end
  end

endmodule

// File: rtl/sclk_ff_emu.sv
module sclk_ff_emu
  import sff_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter ffm_e             MODE      = FFM_ARST,
  parameter bit               CLK_POL   = 1'b1,
  parameter bit               RST_POL   = 1'b1,
  parameter logic [WIDTH-1:0] RST_VALUE = '0,
  parameter bit               SET_POL   = 1'b1,
  parameter bit               CLR_POL   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk,
  input  logic [WIDTH-1:0] md,
  input  logic             mrst,
  input  logic [WIDTH-1:0] mset,
  input  logic [WIDTH-1:0] mclr,
  output logic [WIDTH-1:0] q
);

  localparam bit USE_RST = (MODE == FFM_ARST);
  localparam bit USE_SC  = (MODE == FFM_SETCLR);

  logic             act_edge;
  logic [WIDTH-1:0] d_past;
  logic [WIDTH-1:0] q_past;
  logic             rst_on;
  logic [WIDTH-1:0] set_act;
  logic [WIDTH-1:0] clr_act;
  logic [WIDTH-1:0] qval;
  logic [WIDTH-1:0] q_n;
  logic             frc_any;

  sff_clk_edge #(.CLK_POL(CLK_POL)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .mclk     (mclk),
    .act_edge (act_edge)
  );

  sff_hist #(.WIDTH(WIDTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_now  (md),
    .q_now  (q),
    .d_past (d_past),
    .q_past (q_past)
  );

  sff_rst_hold #(.RST_POL(RST_POL)) u_rhold (
    .clk    (clk),
    .rst_n  (rst_n),
    .mrst   (mrst),
    .rst_on (rst_on)
  );

  sff_force #(.WIDTH(WIDTH), .SET_POL(SET_POL), .CLR_POL(CLR_POL)) u_force (
    .mset    (mset),
    .mclr    (mclr),
    .set_act (set_act),
    .clr_act (clr_act)
  );

  // output selection: edge picks recorded D, else recorded Q
  always_comb begin
    qval = act_edge ? d_past : q_past;
    q_n  = qval;
    if (USE_SC) begin
      q_n = (qval | set_act) & ~clr_act;
    end
    if (USE_RST && rst_on) begin
      q_n = RST_VALUE;
    end
  end

  assign q = q_n;

  assign frc_any = (USE_RST && rst_on) || (USE_SC && ((|set_act) || (|clr_act)));

  // R2
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (mclk == CLK_POL) && ($past(mclk) != CLK_POL) && !frc_any)
      |-> (q == $past(md)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !((mclk == CLK_POL) && ($past(mclk) != CLK_POL)) && !frc_any)
      |-> (q == $past(q)));

  generate
    if (USE_RST) begin : g_rst_chk
      // R8
      rst_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrst == RST_POL) |-> (q == RST_VALUE));
    end
    if (USE_SC) begin : g_sc_chk
      // R10
      clr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q & clr_act) == '0));
      // R9
      set_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((set_act & ~clr_act) & ~q) == '0));
    end
  endgenerate

endmodule

// File: tb/tb_sclk_ff_emu.sv
module tb_sclk_ff_emu;
  import sff_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk;
  logic rst_n;

  // main instance: rising edge, active-high reset, reset value A5
  logic         a_mclk, a_mrst;
  logic [W-1:0] a_md, a_q;
  // falling edge, active-low reset, reset value C3
  logic         n_mclk, n_mrst;
  logic [W-1:0] n_md, n_q;
  // set/clear: rising edge, set active high, clear active low
  logic         s_mclk;
  logic [W-1:0] s_md, s_set, s_clr, s_q;

  int n_chk;
  int n_bad;
  bit done;

  sclk_ff_emu #(.WIDTH(W), .MODE(FFM_ARST), .CLK_POL(1'b1), .RST_POL(1'b1),
                .RST_VALUE(8'hA5)) dut (
    .clk(clk), .rst_n(rst_n), .mclk(a_mclk), .md(a_md), .mrst(a_mrst),
    .mset('0), .mclr('0), .q(a_q));

  sclk_ff_emu #(.WIDTH(W), .MODE(FFM_ARST), .CLK_POL(1'b0), .RST_POL(1'b0),
                .RST_VALUE(8'hC3)) dut_n (
    .clk(clk), .rst_n(rst_n), .mclk(n_mclk), .md(n_md), .mrst(n_mrst),
    .mset('0), .mclr('0), .q(n_q));

  sclk_ff_emu #(.WIDTH(W), .MODE(FFM_SETCLR), .CLK_POL(1'b1), .SET_POL(1'b1),
                .CLR_POL(1'b0)) dut_sc (
    .clk(clk), .rst_n(rst_n), .mclk(s_mclk), .md(s_md), .mrst(1'b0),
    .mset(s_set), .mclr(s_clr), .q(s_q));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  // {mclk, mrst, md, expected q} per global cycle for dut
  localparam logic [17:0] A_TBL [0:20] = '{
    {1'b0, 1'b0, 8'h3C, 8'h00},  // hold, no edge (R3)
    {1'b1, 1'b0, 8'h3C, 8'h3C},  // edge loads prior D (R2)
    {1'b1, 1'b0, 8'h77, 8'h3C},  // level stays high, no reload
    {1'b0, 1'b0, 8'h77, 8'h3C},
    {1'b1, 1'b0, 8'h11, 8'h77},  // prior D, not current (R2)
    {1'b0, 1'b0, 8'h11, 8'h77},
    {1'b0, 1'b1, 8'h11, 8'hA5},  // reset value (R8)
    {1'b0, 1'b0, 8'h11, 8'hA5},  // tail cycle (R6)
    {1'b0, 1'b0, 8'h11, 8'hA5},  // held after reset (R8)
    {1'b1, 1'b0, 8'h11, 8'h11},
    {1'b0, 1'b0, 8'hF0, 8'h11},
    {1'b1, 1'b1, 8'hF0, 8'hA5},  // edge with reset (R12)
    {1'b0, 1'b0, 8'h0F, 8'hA5},
    {1'b1, 1'b0, 8'h0F, 8'h0F},
    {1'b1, 1'b0, 8'h0F, 8'h0F},
    {1'b0, 1'b0, 8'h99, 8'h0F},
    {1'b0, 1'b0, 8'h99, 8'h0F},
    {1'b1, 1'b0, 8'h99, 8'h99},
    {1'b0, 1'b1, 8'h42, 8'hA5},
    {1'b1, 1'b0, 8'h42, 8'hA5},  // edge in tail cycle (R12, R6)
    {1'b0, 1'b0, 8'h42, 8'hA5}
  };

  // {mclk, mrst_n, md, expected q} for dut_n
  localparam logic [17:0] N_TBL [0:6] = '{
    {1'b1, 1'b1, 8'h5A, 8'h00},
    {1'b0, 1'b1, 8'h5A, 8'h5A},  // falling edge loads (R4)
    {1'b1, 1'b1, 8'h66, 8'h5A},
    {1'b1, 1'b0, 8'h66, 8'hC3},  // low reset (R7)
    {1'b0, 1'b1, 8'h66, 8'hC3},  // tail overrides edge (R7, R12)
    {1'b1, 1'b1, 8'h66, 8'hC3},
    {1'b0, 1'b1, 8'h66, 8'h66}
  };

  // {mclk, md, mset, mclr (active low), expected q} for dut_sc
  localparam logic [32:0] S_TBL [0:8] = '{
    {1'b0, 8'hF0, 8'h00, 8'hFF, 8'h00},
    {1'b1, 8'hF0, 8'h00, 8'hFF, 8'hF0},
    {1'b0, 8'hF0, 8'h03, 8'hFF, 8'hF3},  // set (R9)
    {1'b0, 8'hF0, 8'h00, 8'hFF, 8'hF3},  // set persists (R9)
    {1'b0, 8'hF0, 8'h0C, 8'h7B, 8'h7B},  // clear wins bit 2 (R10, R11)
    {1'b0, 8'hF0, 8'h00, 8'hFF, 8'h7B},
    {1'b1, 8'h81, 8'h00, 8'hFE, 8'hF0},  // edge and clear
    {1'b0, 8'h81, 8'h00, 8'hFF, 8'hF0},
    {1'b1, 8'h81, 8'h00, 8'hFF, 8'h81}
  };

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    a_mclk = 1'b0; a_mrst = 1'b0; a_md = '0;
    n_mclk = 1'b1; n_mrst = 1'b1; n_md = '0;
    s_mclk = 1'b0; s_md = '0; s_set = '0; s_clr = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset dut", a_q, 8'h00);
    chk("R1 reset dut_n", n_q, 8'h00);
    chk("R1 reset dut_sc", s_q, 8'h00);

    // table walk, dut (R2 R3 R6 R8 R12)
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i <= 20; i++) begin
      if (i != 0) @(negedge clk);
      {a_mclk, a_mrst, a_md} = A_TBL[i][17:8];
      #1;
      chk($sformatf("R2/R3 table row %0d", i), a_q, A_TBL[i][7:0]);
    end

    for (int i = 0; i <= 6; i++) begin
      @(negedge clk);
      {n_mclk, n_mrst, n_md} = N_TBL[i][17:8];
      #1;
      chk($sformatf("R4/R7 row %0d", i), n_q, N_TBL[i][7:0]);
    end

    for (int i = 0; i <= 8; i++) begin
      @(negedge clk);
      {s_mclk, s_md, s_set, s_clr} = S_TBL[i][32:8];
      #1;
      chk($sformatf("R9/R10/R11 row %0d", i), s_q, S_TBL[i][7:0]);
    end

    // R5: clock held active across reset release
    @(negedge clk);
    rst_n = 1'b0;
    a_mclk = 1'b1; a_mrst = 1'b0; a_md = 8'hFF;
    #1;
    chk("R1 reset again", a_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R5 first cycle", a_q, 8'h00);
    @(negedge clk);
    #1;
    chk("R5 second cycle", a_q, 8'h00);
    @(negedge clk);
    a_mclk = 1'b0;
    #1;
    chk("R3 after wake", a_q, 8'h00);
    @(negedge clk);
    a_mclk = 1'b1;
    #1;
    chk("R2 first real edge", a_q, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule